// File: doc/BRIEF.md
# Byte-Wide EPROM Burn Sequencer

This controller writes a full image into a byte-wide, UV-erasable memory using a bounded pulse-and-check loop. A start command makes it walk the address space from zero upward. The image byte for the current address comes in on a source port, and the source sees the same address bus as the memory. If that byte is all ones, it already matches the erased state and the location is passed over. Otherwise the byte is held on the data bus and the controller fires a fixed-width, active-low program strobe. After each strobe it reads the location back. It fires again until the byte matches or the per-address pulse budget runs out.

Once the last address is programmed, the controller goes back to address zero and reads the whole array twice. The first read pass runs with both supply rails requested at the nominal-high verify level. The second runs with both rails at the low verify level. Only the request codes for the rails are produced. The analog switching is done elsewhere. All intervals are clock-cycle counts set by parameters. The result is reported as done or as fail, with the address that failed.

Top module: `eprom_burner`

## Requirements
- R1: After reset and while idle: busy, done and fail are low; ce_n, oe_n and pgm_n are high; data_oe is low; rail_mode is 2'b00.
- R2: A location whose source byte is all ones receives no program pulse.
- R3: Every program pulse holds pgm_n low for exactly PULSE_CYC clock cycles and then returns it high. pgm_n is never low outside such a pulse.
- R4: When pgm_n falls, ce_n is low, oe_n is high and data_oe is high. mem_addr, mem_wdata, data_oe, ce_n and oe_n have held their values for at least SETUP_CYC cycles. After pgm_n rises, the data stays driven and unchanged for at least HOLD_CYC cycles.
- R5: After every pulse the location is read back with pgm_n high, oe_n low and data_oe low. rd_data is sampled after READ_CYC cycles. On a mismatch another pulse follows, and on a match the controller moves to the next address.
- R6: Each address gets at most MAX_PULSES pulses, and the count restarts at each new address. If read-back still fails after the last allowed pulse, the controller stops, raises fail and reports that address on fail_addr.
- R7: rail_mode is 2'b01 (high-voltage programming) during the whole programming pass, including every pulse and its read-back.
- R8: After programming, every address is read once with rail_mode 2'b10 (6.0 V verify), then once more with rail_mode 2'b11 (4.3 V verify). A mismatch against the source byte raises fail with that address.
- R9: done rises only after both verify passes end with no mismatch. done and fail are never high together. Both hold until the next start, and busy is high from start until one of them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burn run (accepted while idle) |
| src_data | input | DATA_W | Image byte for the current mem_addr |
| rd_data | input | DATA_W | Read-back bus from the memory |
| mem_addr | output | ADDR_W | Address to memory and image source |
| mem_wdata | output | DATA_W | Byte to be programmed |
| data_oe | output | 1 | Drive enable for mem_wdata onto the memory data pins |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| pgm_n | output | 1 | Program strobe, active low, pulsed only |
| rail_mode | output | 2 | Supply request: 00 read, 01 program, 10 verify 6.0 V, 11 verify 4.3 V |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with the whole array verified |
| fail | output | 1 | Run stopped on a failed location |
| fail_addr | output | ADDR_W | Address of the failed location |

## Verification
If the pulse counter or the address register holds a wrong value, the first sign at the ports is the count of strobe pulses at one address, which is measured there. A budget that is off by one gives nine or eleven pulses at a hopeless location within one address period. A corrupted pass or rail state shows in rail_mode during the read cycles, or as done rising without the low-rail pass. A timer fault changes the strobe width or the setup and hold spans, and the bench catches this on the very pulse where it happens.

// File: rtl/eprom_burner.sv
module eprom_burner #(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 2500,
  parameter int SETUP_CYC  = 50,
  parameter int HOLD_CYC   = 50,
  parameter int READ_CYC   = 5,
  parameter int MAX_PULSES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              data_oe,
  output logic              ce_n,
  output logic              oe_n,
  output logic              pgm_n,
  output logic [1:0]        rail_mode,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int TW = $clog2(PULSE_CYC + SETUP_CYC + HOLD_CYC + READ_CYC + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  typedef enum logic [2:0] {
    IDLE, P_CHECK, P_SETUP, P_PULSE, P_HOLD, P_VERIFY, V_WAIT, V_READ
  } st_t;

  st_t st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] npulse;
  logic          pass;
  logic          tdone;
  logic          last;

  assign tdone = (tmr == '0);
  assign last  = (mem_addr == LAST);

  assign busy    = (st != IDLE);
  assign ce_n    = (st == IDLE);
  assign oe_n    = !(st == P_VERIFY || st == V_READ);
  assign pgm_n   = (st != P_PULSE);
  assign data_oe = (st == P_SETUP || st == P_PULSE || st == P_HOLD);

  always_comb begin
    if (st == IDLE)            rail_mode = 2'b00;
    else if (st == V_WAIT || st == V_READ) rail_mode = pass ? 2'b11 : 2'b10;
    else                       rail_mode = 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      tmr       <= '0;
      npulse    <= '0;
      pass      <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      if (!tdone) tmr <= tmr - 1'b1;
      case (st)
        IDLE: if (start) begin
          mem_addr <= '0;
          done     <= 1'b0;
          fail     <= 1'b0;
          pass     <= 1'b0;
          npulse   <= '0;
          st       <= P_CHECK;
        end
        P_CHECK: begin
          if (src_data == {DATA_W{1'b1}}) begin
            if (last) begin
              mem_addr <= '0;
              pass     <= 1'b0;
              tmr      <= TW'(SETUP_CYC - 1);
              st       <= V_WAIT;
            end else begin
              mem_addr <= mem_addr + 1'b1;
            end
          end else begin
            mem_wdata <= src_data;
            npulse    <= '0;
            tmr       <= TW'(SETUP_CYC - 1);
            st        <= P_SETUP;
          end
        end
        P_SETUP: if (tdone) begin
          tmr <= TW'(PULSE_CYC - 1);
          st  <= P_PULSE;
        end
        P_PULSE: if (tdone) begin
          npulse <= npulse + 1'b1;
          tmr    <= TW'(HOLD_CYC - 1);
          st     <= P_HOLD;
        end
        P_HOLD: if (tdone) begin
          tmr <= TW'(READ_CYC - 1);
          st  <= P_VERIFY;
        end
        P_VERIFY: if (tdone) begin
          if (rd_data == mem_wdata) begin
            if (last) begin
              mem_addr <= '0;
              pass     <= 1'b0;
              tmr      <= TW'(SETUP_CYC - 1);
              st       <= V_WAIT;
            end else begin
              mem_addr <= mem_addr + 1'b1;
              st       <= P_CHECK;
            end
          end else if (npulse == PW'(MAX_PULSES)) begin
            fail      <= 1'b1;
            fail_addr <= mem_addr;
            st        <= IDLE;
          end else begin
            tmr <= TW'(SETUP_CYC - 1);
            st  <= P_SETUP;
          end
        end
        V_WAIT: if (tdone) begin
          tmr <= TW'(READ_CYC - 1);
          st  <= V_READ;
        end
        V_READ: if (tdone) begin
          if (rd_data != src_data) begin
            fail      <= 1'b1;
            fail_addr <= mem_addr;
            st        <= IDLE;
          end else if (last) begin
            if (!pass) begin
              pass     <= 1'b1;
              mem_addr <= '0;
              tmr      <= TW'(SETUP_CYC - 1);
              st       <= V_WAIT;
            end else begin
              done <= 1'b1;
              st   <= IDLE;
            end
          end else begin
            mem_addr <= mem_addr + 1'b1;
            tmr      <= TW'(READ_CYC - 1);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [TW-1:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (!pgm_n) low_cnt <= low_cnt + 1'b1;
    else             low_cnt <= '0;
  end

  // R3
  pgm_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_n) |-> $past(low_cnt) == TW'(PULSE_CYC - 1));

  // R3
  pgm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= TW'(PULSE_CYC));

  // R4
  pgm_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgm_n) |-> (!ce_n && oe_n && data_oe && $stable(mem_addr) && $stable(mem_wdata)));

  // R5
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!data_oe && pgm_n));

  // R6
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npulse <= PW'(MAX_PULSES));

  // R7
  pgm_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |-> rail_mode == 2'b01);

  // R8
  done_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rail_mode) == 2'b11);

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pgm_n && ce_n && oe_n && !data_oe));
endmodule

// File: tb/tb_eprom_burner.sv
module tb_eprom_burner;
  localparam int AW = 4, DW = 8, N = 16;
  localparam int PULSE = 8, SETUP = 3, HOLD = 2, READ = 2, MAXP = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [DW-1:0] src_data, rd_data, mem_wdata;
  logic [AW-1:0] mem_addr, fail_addr;
  logic data_oe, ce_n, oe_n, pgm_n, busy, done, fail;
  logic [1:0] rail_mode;

  always #10 clk = ~clk;

  eprom_burner #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP),
    .HOLD_CYC(HOLD), .READ_CYC(READ), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .data_oe(data_oe), .ce_n(ce_n),
    .oe_n(oe_n), .pgm_n(pgm_n), .rail_mode(rail_mode), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr));

  int checks = 0, errors = 0;
  logic [DW-1:0] img [N];
  logic [DW-1:0] mem [N];
  int need [N];
  int pc [N];
  bit weak3 [N];
  int rd2, rd3, total_pulses;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  assign src_data = img[mem_addr];
  always_comb begin
    if (!ce_n && !oe_n)
      rd_data = (rail_mode == 2'b11 && weak3[mem_addr]) ? (mem[mem_addr] ^ 8'h01) : mem[mem_addr];
    else
      rd_data = 8'hFF;
  end

  logic prev_pgm = 1;
  logic [AW+DW+3-1:0] prev_sig = '0;
  int stable_cnt = 0, low_cnt = 0, hold_cnt = 0;
  bit in_hold = 0;
  logic [AW-1:0] lat_a;
  logic [DW-1:0] lat_d;

  always @(negedge clk) if (rst_n) begin
    logic [AW+DW+3-1:0] sig;
    sig = {mem_addr, mem_wdata, data_oe, ce_n, oe_n};
    if (prev_pgm && !pgm_n) begin
      chk(stable_cnt >= SETUP, "R4 setup span", stable_cnt, SETUP);
      chk(!ce_n && oe_n && data_oe, "R4 pulse framing", {ce_n, oe_n, data_oe}, 3'b011);
      chk(rail_mode == 2'b01, "R7 rail during pulse", rail_mode, 1);
      pc[mem_addr]++;
      total_pulses++;
      lat_a = mem_addr; lat_d = mem_wdata;
    end
    if (!prev_pgm && pgm_n) begin
      chk(low_cnt == PULSE, "R3 pulse width", low_cnt, PULSE);
      if (pc[lat_a] >= need[lat_a]) mem[lat_a] = mem[lat_a] & lat_d;
      in_hold = 1; hold_cnt = 0;
    end
    if (in_hold) begin
      if (data_oe && mem_wdata == lat_d && pgm_n) hold_cnt++;
      else begin
        chk(hold_cnt >= HOLD, "R4 hold span", hold_cnt, HOLD);
        in_hold = 0;
      end
    end
    if (!pgm_n) low_cnt++; else low_cnt = 0;
    if (!pgm_n && low_cnt > PULSE) chk(0, "R3 strobe held low", low_cnt, PULSE);
    if (!oe_n && rail_mode == 2'b10) rd2++;
    if (!oe_n && rail_mode == 2'b11) rd3++;
    if (sig == prev_sig) stable_cnt++; else stable_cnt = 1;
    prev_sig = sig;
    prev_pgm = pgm_n;
  end

  task automatic prep();
    for (int i = 0; i < N; i++) begin
      img[i] = 8'hA0 + DW'(i) * 8'h05;
      mem[i] = 8'hFF; need[i] = 1; pc[i] = 0; weak3[i] = 0;
    end
    rd2 = 0; rd3 = 0; total_pulses = 0;
  endtask

  task automatic run();
    int guard = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1, "R9 busy after start", busy, 1);
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    if (guard >= 20000) chk(0, "watchdog", guard, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail, "R1 flags", {busy, done, fail}, 0);
    chk(ce_n && oe_n && pgm_n && !data_oe, "R1 strobes", {ce_n, oe_n, pgm_n, data_oe}, 4'b1110);
    chk(rail_mode == 2'b00, "R1 rail", rail_mode, 0);
  endtask

  task automatic t_plain();
    int ok = 1;
    prep();
    img[2] = 8'hFF; img[15] = 8'hFF;
    run();
    chk(done && !fail, "R9 done clean", {done, fail}, 2'b10);
    for (int i = 0; i < N; i++) if (mem[i] != img[i]) ok = 0;
    chk(ok == 1, "R5 image written", ok, 1);
    chk(total_pulses == 14, "R2 pulses skip 0xFF", total_pulses, 14);
    chk(pc[2] == 0 && pc[15] == 0, "R2 erased bytes untouched", pc[2] + pc[15], 0);
    chk(rd2 == N * READ, "R8 pass 6.0V reads", rd2, N * READ);
    chk(rd3 == N * READ, "R8 pass 4.3V reads", rd3, N * READ);
    @(negedge clk);
    chk(done && !busy && rail_mode == 2'b00, "R9 done held idle", {done, busy}, 2'b10);
  endtask

  task automatic t_slow();
    prep();
    need[5] = 4; need[9] = MAXP;
    run();
    chk(done && !fail, "R5 retry until match", {done, fail}, 2'b10);
    chk(pc[5] == 4, "R5 pulses slow cell", pc[5], 4);
    chk(pc[9] == MAXP, "R6 full budget used", pc[9], MAXP);
    chk(pc[10] == 1, "R6 count restarts", pc[10], 1);
  endtask

  task automatic t_hopeless();
    prep();
    need[3] = MAXP + 1;
    run();
    chk(fail && !done, "R6 fail raised", {fail, done}, 2'b10);
    chk(fail_addr == 3, "R6 fail address", fail_addr, 3);
    chk(pc[3] == MAXP, "R6 pulse budget", pc[3], MAXP);
    chk(pc[4] == 0 && rd2 == 0, "R6 stops", pc[4] + rd2, 0);
  endtask

  task automatic t_weak();
    prep();
    weak3[7] = 1;
    run();
    chk(fail && !done, "R8 low rail fail", {fail, done}, 2'b10);
    chk(fail_addr == 7, "R8 fail address", fail_addr, 7);
    chk(rd2 == N * READ, "R8 first pass complete", rd2, N * READ);
    chk(rd3 == 8 * READ, "R8 second pass stops", rd3, 8 * READ);
  endtask

  task automatic t_blank();
    prep();
    for (int i = 0; i < N; i++) img[i] = 8'hFF;
    run();
    chk(done && total_pulses == 0, "R2 blank image no pulses", total_pulses, 0);
    chk(rd3 == N * READ, "R8 blank verified", rd3, N * READ);
  endtask

  initial begin
    prep();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_slow();
    t_hopeless();
    t_weak();
    t_blank();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule